// File: doc/BRIEF.md
# Serial Flash Erase Command Decoder

This block sits on the slave side of an SPI link (clock polarity modes 0 and 3) inside a 64-megabit paged flash device. It samples the serial clock, chip select and data-in lines with the device's own system clock. While chip select is low it assembles bytes, most significant bit first. It recognises two commands. The first is the sector erase command: a single opcode byte followed by exactly three address bytes. The second is the whole-array erase: a fixed four-byte opcode sequence with no address.

The address field is read in one of two page-size layouts, selected by the `page_mode_bin` input and captured when chip select falls. The decoder turns the page address into a sector index. Sector 0 is split in two halves by one of its lower page bits. When chip select returns high after a well-formed command, the block emits a single-cycle request. Commands that are malformed, truncated, overlong or issued while the device is busy produce no request.

Top module: `erase_cmd_decoder`

## Requirements
- R1: After reset, `erase_req`, `erase_chip` and `cmd_reject` are low and `erase_sector` is zero.
- R2: Opcode 0x7C followed by exactly three address bytes requests a sector erase. With `page_mode_bin`=0 (1056-byte pages), page bits PA12..PA0 sit at address bits 23..11. A nonzero PA12..PA8 value N gives `erase_sector` = N+1, and all lower bits are ignored. The request does not depend on whether the serial clock idles low or high.
- R3: With `page_mode_bin`=1 (1024-byte pages), address bit 23 is ignored and PA12..PA0 sit at bits 22..10. The sector index is otherwise formed as in R2.
- R4: When PA12..PA8 and PA7..PA4 are all zero, PA3 picks the half of sector 0: index 0 when PA3=0 and index 1 when PA3=1. PA3 is address bit 14 in 1056-byte mode and bit 13 in 1024-byte mode.
- R5: A sector erase whose PA12..PA8 are zero but whose PA7..PA4 are nonzero produces a one-cycle `cmd_reject` pulse instead of a request.
- R6: The byte sequence 0xC7, 0x94, 0x80, 0x9A requests an erase of the whole array. This is `erase_req`=1 together with `erase_chip`=1. Any whole or partial bytes sent after the fourth are ignored.
- R7: A first byte that is neither 0x7C nor 0xC7, or any mismatch in bytes 2 to 4 of the whole-array sequence, produces no output.
- R8: A sector erase that ends with fewer than three address bytes, with a partial byte, or with any clock edge beyond the third address byte produces no output. A truncated opcode also produces no output.
- R9: A command during which `busy` is high at any cycle while chip select is low, or at the chip select rise, produces no output.
- R10: The page-size mode is captured when chip select falls. A change of `page_mode_bin` during a command does not affect that command.
- R11: `erase_req` and `cmd_reject` are single-cycle pulses, each following a chip select rise. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock; data are taken on its rising edge |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the device |
| busy | input | 1 | High while an internal operation is running |
| page_mode_bin | input | 1 | 1 selects 1024-byte pages, 0 selects 1056-byte pages |
| erase_req | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | With `erase_req`, marks a whole-array erase |
| erase_sector | output | 6 | Sector index with `erase_req`: 0 and 1 are the two halves of sector 0, 2..32 are sectors 1..31 |
| cmd_reject | output | 1 | One-cycle pulse for a sector 0 address with nonzero PA7..PA4 |

## Verification
The bench builds the decoder with its default parameters. These give three address bytes, a 13-bit page field with a 5-bit sector part and a 4-bit sector-0 guard, and a 6-bit index. With these values the highest sector (index 32) and both sector-0 halves are reachable in both page layouts. Each serial bit lasts several system clocks, so the synchroniser and edge detection see clean edges. The bench also covers the clock idling low and idling high, and a mode change in the middle of a command.

// File: rtl/erase_cmd_pkg.sv
package erase_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_SECTOR,
        ST_CHIP,
        ST_DROP
    } dec_state_e;

    localparam logic [7:0] OP_SECTOR_ERASE = 8'h7C;

    // Expected byte at position k of the whole-array erase sequence.
    function automatic logic [7:0] chip_seq_byte(input logic [1:0] k);
        case (k)
            2'd0:    chip_seq_byte = 8'hC7;
            2'd1:    chip_seq_byte = 8'h94;
            2'd2:    chip_seq_byte = 8'h80;
            default: chip_seq_byte = 8'h9A;
        endcase
    endfunction

endpackage

// File: rtl/erase_cmd_sync.sv
module erase_cmd_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] meta_d, meta_q, stab_d, stab_q;

    always_comb begin
        meta_d = async_in;
        stab_d = meta_q;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= RST_VAL[i];
                stab_q[i] <= RST_VAL[i];
            end else begin
                meta_q[i] <= meta_d[i];
                stab_q[i] <= stab_d[i];
            end
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/erase_cmd_shifter.sv
module erase_cmd_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int BCNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-2:0] sh;
        logic [BCNT_W-1:0] cnt;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.sh  = '0;
            s_d.cnt = '0;
        end else if (sample) begin
            s_d.sh  = {s_q.sh[BYTE_W-3:0], bit_in};
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_done = sample && (s_q.cnt == BCNT_W'(BYTE_W - 1));
    assign byte_val  = {s_q.sh, bit_in};
endmodule

// File: rtl/erase_cmd_sector_map.sv
module erase_cmd_sector_map #(
    parameter int SECT_HI_W    = 5,
    parameter int SECT0_ZERO_W = 4,
    parameter int IDX_W        = 6
) (
    // Address window: one bit wider than the page bits PA12..PA3 so both layouts fit.
    input  logic [SECT_HI_W+SECT0_ZERO_W+1:0] win,
    input  logic                              mode_bin,
    output logic [IDX_W-1:0]                  idx,
    output logic                              bad
);
    localparam int FLD_W = SECT_HI_W + SECT0_ZERO_W + 1;

    logic [FLD_W-1:0]        fld;
    logic [SECT_HI_W-1:0]    hi;
    logic [SECT0_ZERO_W-1:0] guard;
    logic                    half;

    always_comb begin
        fld   = mode_bin ? win[FLD_W-1:0] : win[FLD_W:1];
        hi    = fld[FLD_W-1 -: SECT_HI_W];
        guard = fld[SECT0_ZERO_W:1];
        half  = fld[0];
        if (hi == '0) begin
            idx = IDX_W'(half);
            bad = (guard != '0);
        end else begin
            idx = IDX_W'(hi) + IDX_W'(1);
            bad = 1'b0;
        end
    end
endmodule

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder
    import erase_cmd_pkg::*;
#(
    parameter int ADDR_BYTES   = 3,
    parameter int BYTE_W       = 8,
    parameter int SECT_HI_W    = 5,
    parameter int SECT0_ZERO_W = 4,
    parameter int IDX_W        = 6,
    parameter int CHIP_LEN     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sck,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    input  logic             busy,
    input  logic             page_mode_bin,
    output logic             erase_req,
    output logic             erase_chip,
    output logic [IDX_W-1:0] erase_sector,
    output logic             cmd_reject
);
    localparam int ADDR_W = ADDR_BYTES * BYTE_W;
    localparam int WIN_W  = SECT_HI_W + SECT0_ZERO_W + 2;
    localparam int WIN_LO = ADDR_W - WIN_W;
    localparam int CNT_W  = $clog2(ADDR_BYTES + CHIP_LEN + 1);
    localparam logic [CNT_W-1:0] SECT_FULL = CNT_W'(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CHIP_FULL = CNT_W'(CHIP_LEN);

    typedef struct packed {
        dec_state_e        st;
        logic [CNT_W-1:0]  nbytes;
        logic [ADDR_W-1:0] addr;
        logic              mode;
        logic              busy_seen;
        logic              sck_prev;
        logic              cs_prev;
        logic              req;
        logic              chip;
        logic [IDX_W-1:0]  sect;
        logic              rej;
    } dec_t;

    localparam dec_t DEC_RST = '{
        st: ST_IDLE, nbytes: '0, addr: '0, mode: 1'b0, busy_seen: 1'b0,
        sck_prev: 1'b0, cs_prev: 1'b1, req: 1'b0, chip: 1'b0, sect: '0, rej: 1'b0
    };

    dec_t q, d;

    logic [2:0]        lines;
    logic              sck_lvl, cs_lvl, mosi_lvl;
    logic              sck_rise, cs_fall, cs_rise, sample;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic [IDX_W-1:0]  sec_idx;
    logic              sec_bad;

    erase_cmd_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_mosi, spi_cs_n, spi_sck}),
        .sync_out (lines)
    );

    assign sck_lvl  = lines[0];
    assign cs_lvl   = lines[1];
    assign mosi_lvl = lines[2];
    assign sck_rise = sck_lvl && !q.sck_prev;
    assign cs_fall  = !cs_lvl && q.cs_prev;
    assign cs_rise  = cs_lvl && !q.cs_prev;
    assign sample   = sck_rise && !cs_lvl;

    erase_cmd_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_fall),
        .sample    (sample),
        .bit_in    (mosi_lvl),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    erase_cmd_sector_map #(
        .SECT_HI_W    (SECT_HI_W),
        .SECT0_ZERO_W (SECT0_ZERO_W),
        .IDX_W        (IDX_W)
    ) u_map (
        .win      (q.addr[ADDR_W-1:WIN_LO]),
        .mode_bin (q.mode),
        .idx      (sec_idx),
        .bad      (sec_bad)
    );

    always_comb begin
        d          = q;
        d.sck_prev = sck_lvl;
        d.cs_prev  = cs_lvl;
        d.req      = 1'b0;
        d.chip     = 1'b0;
        d.rej      = 1'b0;
        d.sect     = '0;

        if (cs_fall) begin
            d.st        = ST_OPCODE;
            d.nbytes    = '0;
            d.addr      = '0;
            d.mode      = page_mode_bin;
            d.busy_seen = busy;
        end else if (q.st != ST_IDLE) begin
            if (busy) d.busy_seen = 1'b1;
            if (cs_rise) begin
                d.st = ST_IDLE;
                if (!q.busy_seen && !busy) begin
                    if (q.st == ST_SECTOR && q.nbytes == SECT_FULL) begin
                        if (sec_bad) begin
                            d.rej = 1'b1;
                        end else begin
                            d.req  = 1'b1;
                            d.sect = sec_idx;
                        end
                    end else if (q.st == ST_CHIP && q.nbytes >= CHIP_FULL) begin
                        d.req  = 1'b1;
                        d.chip = 1'b1;
                    end
                end
            end else if (sample) begin
                case (q.st)
                    ST_OPCODE: begin
                        if (byte_done) begin
                            d.nbytes = CNT_W'(1);
                            if (byte_val == OP_SECTOR_ERASE)    d.st = ST_SECTOR;
                            else if (byte_val == chip_seq_byte(2'd0)) d.st = ST_CHIP;
                            else                                d.st = ST_DROP;
                        end
                    end
                    ST_SECTOR: begin
                        if (q.nbytes == SECT_FULL) begin
                            d.st = ST_DROP;
                        end else if (byte_done) begin
                            d.addr   = {q.addr[ADDR_W-BYTE_W-1:0], byte_val};
                            d.nbytes = q.nbytes + 1'b1;
                        end
                    end
                    ST_CHIP: begin
                        if (byte_done && q.nbytes < CHIP_FULL) begin
                            if (byte_val != chip_seq_byte(q.nbytes[1:0])) d.st = ST_DROP;
                            else d.nbytes = q.nbytes + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= DEC_RST;
        else        q <= d;
    end

    assign erase_req    = q.req;
    assign erase_chip   = q.chip;
    assign erase_sector = q.sect;
    assign cmd_reject   = q.rej;
endmodule

// File: rtl/erase_cmd_decoder_chk.sv
module erase_cmd_decoder_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             cs_rise,
    input logic             erase_req,
    input logic             erase_chip,
    input logic [IDX_W-1:0] erase_sector,
    input logic             cmd_reject
);
    assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    assert_rej_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |=> !cmd_reject);

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_req && cmd_reject));

    assert_after_cs_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req || cmd_reject) |-> $past(cs_rise));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !$past(busy));

    assert_sector_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_chip) |-> (erase_sector <= IDX_W'(32)));

    assert_chip_only_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_chip |-> erase_req);
endmodule

bind erase_cmd_decoder erase_cmd_decoder_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .cs_rise      (cs_rise),
    .erase_req    (erase_req),
    .erase_chip   (erase_chip),
    .erase_sector (erase_sector),
    .cmd_reject   (cmd_reject)
);

// File: tb/erase_cmd_decoder_bench.sv
module erase_cmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic busy = 1'b0, page_mode_bin = 1'b0;
    logic erase_req, erase_chip, cmd_reject;
    logic [5:0] erase_sector;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        bit    rej;
        bit    chip;
        int    sect;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] cmd_buf [8];
    bit prev_pulse = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    erase_cmd_decoder u_erase_cmd_decoder (
        .clk           (clk),
        .rst_n         (rst_n),
        .spi_sck       (spi_sck),
        .spi_cs_n      (spi_cs_n),
        .spi_mosi      (spi_mosi),
        .busy          (busy),
        .page_mode_bin (page_mode_bin),
        .erase_req     (erase_req),
        .erase_chip    (erase_chip),
        .erase_sector  (erase_sector),
        .cmd_reject    (cmd_reject)
    );

    // Monitor: pops one expected item per output pulse.
    always @(negedge clk) begin
        if (rst_n && (erase_req || cmd_reject)) begin
            total++;
            if (prev_pulse) begin
                bad++;
                $display("FAIL R11 pulse longer than one cycle: actual=2+ expected=1");
            end else if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected pulse: actual req=%0b rej=%0b expected none",
                         erase_req, cmd_reject);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (erase_req && cmd_reject) begin
                    bad++;
                    $display("FAIL R11 %s: actual req=1 rej=1 expected one of them", e.tag);
                end else if (cmd_reject != e.rej || erase_chip != e.chip ||
                             (erase_req && !e.chip && int'(erase_sector) != e.sect)) begin
                    bad++;
                    $display("FAIL %s: actual rej=%0b chip=%0b sect=%0d expected rej=%0b chip=%0b sect=%0d",
                             e.tag, cmd_reject, erase_chip, erase_sector, e.rej, e.chip, e.sect);
                end
            end
            prev_pulse = 1;
        end else begin
            prev_pulse = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send(input int nbytes, input int extra_bits, input bit mode,
                        input bit bsy, input bit idle_hi, input bit flip_mode);
        spi_sck       = idle_hi;
        page_mode_bin = mode;
        busy          = bsy;
        repeat (4) @(posedge clk);
        spi_cs_n = 1'b0;
        repeat (4) @(posedge clk);
        for (int i = 0; i < nbytes * 8 + extra_bits; i++) begin
            spi_sck  = 1'b0;
            spi_mosi = cmd_buf[i / 8][7 - (i % 8)];
            if (flip_mode && i == 8) page_mode_bin = ~mode;
            repeat (HALF_BIT) @(posedge clk);
            spi_sck = 1'b1;
            repeat (HALF_BIT) @(posedge clk);
        end
        spi_sck = idle_hi;
        repeat (4) @(posedge clk);
        spi_cs_n = 1'b1;
        repeat (6) @(posedge clk);
        busy = 1'b0;
        page_mode_bin = mode;
    endtask

    task automatic settle(input string tag);
        repeat (20) @(posedge clk);
        @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL %s: actual=no pulse expected=%0d pending pulse(s)", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    function automatic logic [23:0] addr_of(input int page, input bit bin);
        if (bin) return 24'h800000 | (24'(page) << 10) | 24'h155;
        return (24'(page) << 11) | 24'h3A5;
    endfunction

    task automatic load_sector(input int page, input bit bin);
        logic [23:0] a;
        a = addr_of(page, bin);
        cmd_buf[0] = 8'h7C;
        cmd_buf[1] = a[23:16];
        cmd_buf[2] = a[15:8];
        cmd_buf[3] = a[7:0];
        cmd_buf[4] = 8'h5A;
    endtask

    task automatic load_chip();
        cmd_buf[0] = 8'hC7;
        cmd_buf[1] = 8'h94;
        cmd_buf[2] = 8'h80;
        cmd_buf[3] = 8'h9A;
        cmd_buf[4] = 8'h33;
        cmd_buf[5] = 8'hFF;
        cmd_buf[6] = 8'h0F;
    endtask

    task automatic expect_sector(input int page, input string tag);
        exp_t e;
        int hi;
        hi     = (page >> 8) & 31;
        e.chip = 0;
        e.tag  = tag;
        if (hi == 0) begin
            e.sect = (page >> 3) & 1;
            e.rej  = ((page >> 4) & 15) != 0;
        end else begin
            e.sect = hi + 1;
            e.rej  = 0;
        end
        exp_q.push_back(e);
    endtask

    task automatic expect_chip(input string tag);
        exp_t e;
        e.rej = 0; e.chip = 1; e.sect = 0; e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (erase_req !== 1'b0 || erase_chip !== 1'b0 || cmd_reject !== 1'b0 || erase_sector !== 6'd0) begin
            bad++;
            $display("FAIL R1 reset outputs: actual req=%b chip=%b rej=%b sect=%0d expected all zero",
                     erase_req, erase_chip, cmd_reject, erase_sector);
        end
        rst_n = 1'b1;
        repeat (5) @(posedge clk);

        // R2: 1056-byte layout, several sectors, both clock idle levels
        load_sector(13'h0507, 0); expect_sector(13'h0507, "R2 sector 5 ext");
        send(4, 0, 0, 0, 0, 0); settle("R2 sector 5 ext");
        load_sector(13'h1FFF, 0); expect_sector(13'h1FFF, "R2 sector 31 ext");
        send(4, 0, 0, 0, 0, 0); settle("R2 sector 31 ext");
        load_sector(13'h0100, 0); expect_sector(13'h0100, "R2 sector 1 idle high");
        send(4, 0, 0, 0, 1, 0); settle("R2 sector 1 idle high");

        // R3: 1024-byte layout, bit 23 set as don't care
        load_sector(13'h11A3, 1); expect_sector(13'h11A3, "R3 sector 17 bin");
        send(4, 0, 1, 0, 0, 0); settle("R3 sector 17 bin");
        load_sector(13'h1F00, 1); expect_sector(13'h1F00, "R3 sector 31 bin");
        send(4, 0, 1, 0, 0, 0); settle("R3 sector 31 bin");

        // R4: sector 0 halves
        load_sector(13'h0007, 0); expect_sector(13'h0007, "R4 sector 0a ext");
        send(4, 0, 0, 0, 0, 0); settle("R4 sector 0a ext");
        load_sector(13'h0008, 0); expect_sector(13'h0008, "R4 sector 0b ext");
        send(4, 0, 0, 0, 0, 0); settle("R4 sector 0b ext");
        load_sector(13'h000F, 1); expect_sector(13'h000F, "R4 sector 0b bin");
        send(4, 0, 1, 0, 0, 0); settle("R4 sector 0b bin");

        // R5: sector 0 guard bits nonzero
        load_sector(13'h0018, 0); expect_sector(13'h0018, "R5 guard ext");
        send(4, 0, 0, 0, 0, 0); settle("R5 guard ext");
        load_sector(13'h0080, 1); expect_sector(13'h0080, "R5 guard bin");
        send(4, 0, 1, 0, 0, 0); settle("R5 guard bin");

        // R6: whole-array erase, exact and with trailing data
        load_chip(); expect_chip("R6 chip exact");
        send(4, 0, 0, 0, 0, 0); settle("R6 chip exact");
        load_chip(); expect_chip("R6 chip trailing");
        send(6, 3, 1, 0, 1, 0); settle("R6 chip trailing");

        // R7: mismatches
        load_chip(); cmd_buf[2] = 8'h81;
        send(4, 0, 0, 0, 0, 0); settle("R7 chip third byte wrong");
        load_chip(); cmd_buf[3] = 8'h9B;
        send(4, 0, 0, 0, 0, 0); settle("R7 chip fourth byte wrong");
        load_sector(13'h0500, 0); cmd_buf[0] = 8'h7D;
        send(4, 0, 0, 0, 0, 0); settle("R7 unknown opcode");

        // R8: truncated or overlong
        load_sector(13'h0500, 0);
        send(3, 0, 0, 0, 0, 0); settle("R8 two address bytes");
        send(3, 5, 0, 0, 0, 0); settle("R8 partial third byte");
        send(4, 1, 0, 0, 0, 0); settle("R8 extra bit");
        send(5, 0, 0, 0, 0, 0); settle("R8 fourth address byte");
        send(0, 5, 0, 0, 0, 0); settle("R8 partial opcode");
        load_chip();
        send(3, 4, 0, 0, 0, 0); settle("R8 chip partial");

        // R9: busy
        load_sector(13'h0500, 0);
        send(4, 0, 0, 1, 0, 0); settle("R9 busy sector");
        load_chip();
        send(4, 0, 0, 1, 0, 0); settle("R9 busy chip");
        load_sector(13'h0A00, 0); expect_sector(13'h0A00, "R9 after busy cleared");
        send(4, 0, 0, 0, 0, 0); settle("R9 after busy cleared");

        // R10: mode change mid-command takes no effect
        load_sector(13'h0C00, 0); expect_sector(13'h0C00, "R10 flip to bin");
        send(4, 0, 0, 0, 0, 1); settle("R10 flip to bin");
        load_sector(13'h0C08, 1); expect_sector(13'h0C08, "R10 flip to ext");
        send(4, 0, 1, 0, 0, 1); settle("R10 flip to ext");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule